// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

The block collects a small group of hardware event lines and presents them to a parent interrupt controller as one level-sensitive request. Software controls and observes it through a single 32-bit register: the low half carries read/write enable bits, and the high half carries sticky status bits. A status bit always sits exactly 16 positions above the enable bit of the same source, so software can move between the two views with a shift.

Status bits latch on a rising edge of their source. They latch whether the source is enabled or not, and they stay set until software writes a 1 to them. Writing 0 to a status bit has no effect, so enables can be rewritten at any time without losing pending events. The request output is high while any source has both its status and its enable bit set. Two parameters choose how many sources exist and at which enable bit they begin. Every other bit reads as 0 and ignores writes.

Top module: `irq_aggregator`

## Requirements
- R1: During and right after reset, the register reads as 0 and `irq_out` is low.
- R2: A write loads enable bits `SRC_BASE` to `SRC_BASE+NUM_SRC-1` from the same positions of `wr_data`. The new value reads back after the clock edge that samples the strobe, and it holds when no write occurs.
- R3: A 0-to-1 transition on `src_in[i]` (sampled at two consecutive clock edges) sets status bit `SRC_BASE+i+16` at the second of those edges, whatever the state of enable bit `SRC_BASE+i`.
- R4: Writing 1 to an in-range status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: When a clear and a new rising edge reach the same status bit in the same cycle, the bit ends up set.
- R6: `irq_out` is high exactly when some source has both its status bit and its enable bit set. It stays high until every such status bit is cleared or disabled.
- R7: Register bits outside the configured enable and status positions, including bits 31 to 29, always read 0, and writes to them have no effect.
- R8: A source held high does not set its status bit again once that bit has been cleared. Only a new rising edge sets it.
- R9: Writing ones to bits 28 to 16 and then writing 0 to the whole register leaves every status and enable bit cleared and `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: enables in the low half, write-1-to-clear status in the high half |
| rd_data | output | 32 | Current register contents |
| src_in | input | NUM_SRC | Event lines; bit i belongs to source i |
| irq_out | output | 1 | Level request to the parent controller |

## Verification
The edge properties assume the event lines are held low while reset is asserted. The block's edge history is reset to 0, while the checker's view of the previous input comes from the actual pin value, and the two only agree if the pin was low. The bench therefore keeps `src_in` at 0 until reset is released. From then on it changes both sources and register writes only at falling clock edges, so every transition the properties look for falls cleanly between two sampling edges.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int REG_W   = 32;
  localparam int STS_OFS = 16;   // status bit = enable bit + STS_OFS
  localparam int STS_TOP = 28;   // highest implemented status position

  // Mask of n consecutive bits starting at lo, within a register word.
  function automatic logic [REG_W-1:0] field_mask(input int lo, input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < n; k++) m[lo + k] = 1'b1;
    return m;
  endfunction

  // Register position of the status bit that belongs to an enable position.
  function automatic int status_pos(input int en_pos);
    return en_pos + STS_OFS;
  endfunction
endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= level_i;
  end

  assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/irqagg_cell.sv
module irqagg_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,   // register write strobe
  input  logic en_d_i,   // enable value from write data
  input  logic clr_i,    // write-1-to-clear for status
  input  logic evt_i,    // rising edge of the source
  output logic en_o,
  output logic sts_o
);
  logic en_q, sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (load_i) en_q <= en_d_i;
      // a new event wins over a clear in the same cycle
      sts_q <= evt_i | (sts_q & ~clr_i);
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int SRC_BASE = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_out
);
  localparam int EN_LO  = SRC_BASE;
  localparam int STS_LO = EN_LO + STS_OFS;

  // named internal events, visible to assertions and waveforms
  logic [NUM_SRC-1:0] src_rise;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] sts_vec;
  logic [NUM_SRC-1:0] pend_vec;

  irqagg_edge #(.W(NUM_SRC)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (src_in),
    .rise_o  (src_rise)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    irqagg_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wr_en),
      .en_d_i (wr_data[EN_LO + i]),
      .clr_i  (wr_en & wr_data[status_pos(EN_LO + i)]),
      .evt_i  (src_rise[i]),
      .en_o   (en_vec[i]),
      .sts_o  (sts_vec[i])
    );
  end

  assign pend_vec = en_vec & sts_vec;
  assign irq_out  = |pend_vec;

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      rd_data[EN_LO + k]  = en_vec[k];
      rd_data[STS_LO + k] = sts_vec[k];
    end
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC  = 6,
  parameter int SRC_BASE = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [31:0]        wr_data,
  input logic [31:0]        rd_data,
  input logic [NUM_SRC-1:0] src_in,
  input logic               irq_out
);
  localparam logic [31:0] EN_M  = field_mask(SRC_BASE, NUM_SRC);
  localparam logic [31:0] STS_M = field_mask(SRC_BASE + STS_OFS, NUM_SRC);

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~(EN_M | STS_M)) == 32'd0);                                   // R7
  AST_IRQ_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|((rd_data >> STS_OFS) & rd_data & EN_M)));                  // R6
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & EN_M) == ($past(wr_data) & EN_M)));                // R2
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data & EN_M));                                     // R2

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int SP = SRC_BASE + i + STS_OFS;
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in[i] && !$past(src_in[i])) |=> rd_data[SP]);                     // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[SP] && !(src_in[i] && !$past(src_in[i]))) |=> !rd_data[SP]); // R4
    AST_STATUS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[SP] && !(wr_en && wr_data[SP])) |=> rd_data[SP]);             // R4
    AST_NO_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_data[SP] && !(src_in[i] && !$past(src_in[i]))) |=> !rd_data[SP]);  // R8
  end
endmodule

bind irq_aggregator irqagg_checker #(.NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .src_in  (src_in),
  .irq_out (irq_out)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 3;
  localparam int BS = 4;
  localparam int SL = BS + 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NS-1:0] src_in = '0;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [NS-1:0] exp_en = '0, exp_sts = '0, prev_src = '0;

  irq_aggregator #(.NUM_SRC(NS), .SRC_BASE(BS)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_in(src_in), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_reg();
    return (32'(exp_sts) << SL) | (32'(exp_en) << BS);
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (rd_data !== exp_reg()) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_reg());
    end
    n_chk++;
    if (irq_out !== (|(exp_sts & exp_en))) begin
      n_bad++;
      $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, |(exp_sts & exp_en));
    end
  endtask

  // One clock: drive at falling edge, update model, check at next falling edge.
  task automatic cyc(input logic we, input logic [31:0] wd, input logic [NS-1:0] s,
                     input string tag);
    logic [NS-1:0] rise, clr;
    wr_en = we; wr_data = wd; src_in = s;
    rise = s & ~prev_src;
    clr  = we ? wd[SL +: NS] : '0;
    exp_sts = (exp_sts & ~clr) | rise;
    if (we) exp_en = wd[BS +: NS];
    prev_src = s;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");                          // during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");                          // after release

    // R2: every enable pattern, then hold without writes
    for (int e = 0; e < (1 << NS); e++) cyc(1'b1, 32'(e) << BS, '0, "R2");
    cyc(1'b0, 32'hFFFF_FFFF, '0, "R2");   // data ignored without strobe

    // R7: writes to bits outside the configured fields
    cyc(1'b1, 32'hFFFF_FFFF, '0, "R7");
    cyc(1'b1, ~((32'((1 << NS) - 1) << BS) | (32'((1 << NS) - 1) << SL)), '0, "R7");
    cyc(1'b1, 32'h0000_0000, '0, "R7");

    // R3: each source with enables off sets only its own status
    for (int i = 0; i < NS; i++) begin
      cyc(1'b0, '0, NS'(1 << i), "R3");
      cyc(1'b0, '0, '0, "R3");
    end

    // R4: clear one status bit at a time, others stay
    for (int i = 0; i < NS; i++) cyc(1'b1, 32'(1) << (SL + i), '0, "R4");
    cyc(1'b0, '0, '1, "R4");
    cyc(1'b1, 32'(1) << BS, '1, "R4");    // enable write with status zeros keeps status

    // R8: level held high after a clear does not re-set
    cyc(1'b1, 32'(((1 << NS) - 1)) << SL, '1, "R8");
    cyc(1'b0, '0, '1, "R8");
    cyc(1'b0, '0, '1, "R8");

    // R5: clear and new edge in one cycle
    cyc(1'b0, '0, '0, "R5");
    cyc(1'b1, 32'(((1 << NS) - 1)) << SL, '1, "R5");

    // R6: all enable x status combinations
    for (int e = 0; e < (1 << NS); e++) begin
      for (int s = 0; s < (1 << NS); s++) begin
        cyc(1'b1, 32'h1FFF_0000, '0, "R6");
        cyc(1'b0, '0, NS'(s), "R6");
        cyc(1'b0, '0, '0, "R6");
        cyc(1'b1, 32'(e) << BS, '0, "R6");
        cyc(1'b0, '0, '0, "R6");          // level persists
      end
    end

    // R9: ones into status field then zero
    cyc(1'b1, 32'h0000_FFFF, '1, "R9");
    cyc(1'b1, 32'h1FFF_0000, '1, "R9");
    cyc(1'b1, 32'h0000_0000, '1, "R9");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule